// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block turns single-byte host requests into timed bus cycles on the pins of an 8-bit NAND flash device. The host picks one of four operations: command byte, address byte, data write or data read. The block then drives the latch-enable lines, the active-low write and read strobes, and the output enable of the data bus. Every cycle has three phases, each a whole number of system clock ticks: setup before the strobe, the strobe itself, and hold after it. Each phase length is a configuration field that holds the tick count minus one. Requests use a ready/request handshake. The end of every cycle is marked by a one-cycle acknowledge, and read data is valid on the same cycle as the acknowledge.

A configuration write port sets the controller enable bit, the software-held chip-enable bit, the three phase fields, and an init bit. The init bit is passed out as a one-cycle pulse to an external ECC engine. For every data byte that moves across the bus, the ECC engine also gets a one-cycle valid strobe together with the byte. The ready/busy pin passes through a synchroniser and is reported on a status output. The phase fields are sampled only when a cycle begins, so changing them never disturbs a cycle that is already running.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset: chip enable is deasserted (`nand_ce_n`=1), both strobes are high, `nand_cle`, `nand_ale`, `nand_dq_oe`, `host_ready`, `host_ack`, `ecc_init_pulse` and `ecc_byte_valid` are 0, and the controller is disabled.
- R2: A command request (`host_op`=0) keeps `nand_cle`=1 and `nand_ale`=0 for the whole cycle, and drives the byte on `nand_dq_out` with `nand_dq_oe`=1. `nand_cle` and `nand_ale` are never high together.
- R3: An address request (`host_op`=1) keeps `nand_ale`=1 and `nand_cle`=0 for the whole cycle, and drives the byte with `nand_dq_oe`=1.
- R4: A data write (`host_op`=2) keeps both `nand_cle` and `nand_ale` at 0, drives the byte with `nand_dq_oe`=1, and pulses `nand_we_n` low. `nand_re_n` stays high.
- R5: After acceptance, the cycle spends setup+1 clocks with the strobe high, then strobe+1 clocks with the strobe low, then hold+1 clocks before `host_ack`. The strobe and hold fields are 3 bits wide, giving 1 to 8 ticks each.
- R6: With `WIDE_SETUP`=0, only bits 1:0 of `cfg_setup` count and bit 2 is ignored, giving 1 to 4 ticks. With `WIDE_SETUP`=1, all 3 bits count, giving 1 to 8 ticks.
- R7: A data read (`host_op`=3) pulses `nand_re_n` low with `nand_dq_oe`=0 and `nand_we_n` high. `host_rdata` returns the bus value present on the last strobe tick and is valid while `host_ack`=1.
- R8: `nand_ce_n` equals the last written `cfg_chip_off` bit and holds that value across bus cycles.
- R9: `stat_ready` follows `nand_rb` (1 = ready) two clock edges after a change, and not after one.
- R10: While the enable bit is clear, `host_ready`=0, requests are ignored (no strobe, no acknowledge), and a cycle in progress is dropped with both strobes released.
- R11: A configuration write with `cfg_ecc_init`=1 produces exactly one `ecc_init_pulse` cycle. A write without it produces none.
- R12: Each data read or write raises `ecc_byte_valid` for exactly one cycle, the first hold cycle, with `ecc_byte` equal to the transferred byte. Command and address cycles raise it never.
- R13: `host_ready` is 0 from acceptance until the cycle completes. `host_ack` is a one-cycle pulse, and `host_ready` is already 1 in the acknowledge cycle.
- R14: A cycle uses the phase fields held before the edge that accepts it. Configuration writes on that edge or later in the cycle affect only the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Controller enable bit |
| cfg_chip_off | input | 1 | Chip-enable bit, 1 deasserts `nand_ce_n` |
| cfg_ecc_init | input | 1 | Request an ECC init pulse |
| cfg_setup | input | 3 | Setup phase field, ticks minus one |
| cfg_strobe | input | 3 | Strobe phase field, ticks minus one |
| cfg_hold | input | 3 | Hold phase field, ticks minus one |
| host_req | input | 1 | Host request |
| host_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| host_wdata | input | DATA_W | Byte for command, address or write |
| host_ready | output | 1 | Sequencer can accept a request |
| host_ack | output | 1 | One-cycle end-of-cycle pulse |
| host_rdata | output | DATA_W | Byte captured by the last read |
| stat_ready | output | 1 | Synchronised ready/busy, 1 = ready |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DATA_W | Bus value driven to the device |
| nand_dq_oe | output | 1 | Bus output enable for the pad tristate |
| nand_dq_in | input | DATA_W | Bus value from the device |
| nand_rb | input | 1 | Raw ready/busy pin |
| ecc_init_pulse | output | 1 | ECC accumulator clear pulse |
| ecc_byte_valid | output | 1 | Data byte valid for the ECC engine |
| ecc_byte | output | DATA_W | Byte for the ECC engine |

## Verification
Two events can land on the same clock edge. The first is a configuration write, which can fall on the edge that accepts a new request. The second is the acknowledge of one cycle, which can coincide with the acceptance of the next request. The bench provokes the first case by raising `cfg_we` with new phase fields in the same clock period as `host_req`, and again part-way through a cycle. It then measures the setup, strobe and hold lengths at the pins: they must match the old fields for that cycle and the new fields for the next one. It judges the second case by checking that `host_ready` is already high in the acknowledge cycle, and by issuing requests back to back.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int FIELD_W = 3;

  localparam logic [1:0] OP_CMD   = 2'd0;
  localparam logic [1:0] OP_ADDR  = 2'd1;
  localparam logic [1:0] OP_WDATA = 2'd2;
  localparam logic [1:0] OP_RDATA = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] strobe;
    logic [FIELD_W-1:0] hold;
  } timing_t;

  // Effective setup field: the base variant keeps only the two low bits.
  function automatic logic [FIELD_W-1:0] setup_field(input logic [FIELD_W-1:0] raw,
                                                     input bit wide);
    logic [FIELD_W-1:0] f;
    f = raw;
    if (!wide) f[FIELD_W-1] = 1'b0;
    return f;
  endfunction

  // Tick count of a phase from its stored field.
  function automatic logic [FIELD_W:0] field_ticks(input logic [FIELD_W-1:0] f);
    return {1'b0, f} + {{FIELD_W{1'b0}}, 1'b1};
  endfunction

  function automatic bit is_data_op(input logic [1:0] op);
    return (op == OP_WDATA) || (op == OP_RDATA);
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync
);
  localparam int NSTG = (STAGES < 2) ? 2 : STAGES;

  logic [NSTG-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[NSTG-2:0], rb_async};
  end

  assign rb_sync = chain_q[NSTG-1];

endmodule

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_seq_pkg::*;
#(
  parameter bit WIDE_SETUP = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_enable,
  input  logic               cfg_chip_off,
  input  logic               cfg_ecc_init,
  input  logic [FIELD_W-1:0] cfg_setup,
  input  logic [FIELD_W-1:0] cfg_strobe,
  input  logic [FIELD_W-1:0] cfg_hold,
  output logic               en_q,
  output logic               ce_n_q,
  output timing_t            timing_q,
  output logic               init_pulse_q
);
  localparam logic [FIELD_W-1:0] FIELD_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q            <= 1'b0;
      ce_n_q          <= 1'b1;
      timing_q.setup  <= setup_field(FIELD_MAX, WIDE_SETUP);
      timing_q.strobe <= FIELD_MAX;
      timing_q.hold   <= FIELD_MAX;
      init_pulse_q    <= 1'b0;
    end else begin
      init_pulse_q <= cfg_we && cfg_ecc_init;
      if (cfg_we) begin
        en_q            <= cfg_enable;
        ce_n_q          <= cfg_chip_off;
        timing_q.setup  <= setup_field(cfg_setup, WIDE_SETUP);
        timing_q.strobe <= cfg_strobe;
        timing_q.hold   <= cfg_hold;
      end
    end
  end

  // R11: a pulse only ever follows a write that carried the init bit
  assert_init_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse_q |-> $past(cfg_we && cfg_ecc_init));

  // R6: in the base variant the stored setup field never exceeds three
  assert_setup_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    WIDE_SETUP || (timing_q.setup[FIELD_W-1] == 1'b0));

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  timing_t           timing,
  input  logic              req,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ready,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ecc_valid,
  output logic [DATA_W-1:0] ecc_byte,
  output logic              accept,
  output logic              phase_done
);
  phase_e             phase_q;
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] strobe_lat_q;
  logic [FIELD_W-1:0] hold_lat_q;
  logic [1:0]         op_q;
  logic               is_read_q;

  // Named events for the checks and the top level
  assign ready      = en && (phase_q == PH_IDLE);
  assign accept     = req && ready;
  assign phase_done = (phase_q != PH_IDLE) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      strobe_lat_q <= '0;
      hold_lat_q   <= '0;
      op_q         <= OP_CMD;
      is_read_q    <= 1'b0;
      ack          <= 1'b0;
      rdata        <= '0;
      cle          <= 1'b0;
      ale          <= 1'b0;
      we_n         <= 1'b1;
      re_n         <= 1'b1;
      dq_out       <= '0;
      dq_oe        <= 1'b0;
      ecc_valid    <= 1'b0;
      ecc_byte     <= '0;
    end else if (!en) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      ack       <= 1'b0;
      cle       <= 1'b0;
      ale       <= 1'b0;
      we_n      <= 1'b1;
      re_n      <= 1'b1;
      dq_oe     <= 1'b0;
      ecc_valid <= 1'b0;
    end else begin
      ack       <= 1'b0;
      ecc_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q      <= PH_SETUP;
            cnt_q        <= timing.setup;
            strobe_lat_q <= timing.strobe;
            hold_lat_q   <= timing.hold;
            op_q         <= op;
            is_read_q    <= (op == OP_RDATA);
            cle          <= (op == OP_CMD);
            ale          <= (op == OP_ADDR);
            dq_oe        <= (op != OP_RDATA);
            dq_out       <= wdata;
          end
        end
        PH_SETUP: begin
          if (phase_done) begin
            phase_q <= PH_STROBE;
            cnt_q   <= strobe_lat_q;
            if (is_read_q) re_n <= 1'b0;
            else           we_n <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (phase_done) begin
            phase_q <= PH_HOLD;
            cnt_q   <= hold_lat_q;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            if (is_read_q) rdata <= dq_in;
            if (is_data_op(op_q)) begin
              ecc_valid <= 1'b1;
              ecc_byte  <= is_read_q ? dq_in : dq_out;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (phase_done) begin
            phase_q <= PH_IDLE;
            ack     <= 1'b1;
            cle     <= 1'b0;
            ale     <= 1'b0;
            dq_oe   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2: latch enables are mutually exclusive
  assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R7: never strobe both directions, never drive the bus during a read strobe
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n) && (!re_n -> !dq_oe));

  // R10: a disabled controller releases both strobes on the next cycle
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (we_n && re_n && !ack));

  // R12: the ECC valid strobe only appears during data cycles
  assert_ecc_data_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_valid |-> (!cle && !ale));

  // R13: no new request is accepted while a cycle is in progress
  assert_serialised_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> !ready);

  // R13: the acknowledge is a single-cycle pulse
  assert_ack_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter bit WIDE_SETUP  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_enable,
  input  logic              cfg_chip_off,
  input  logic              cfg_ecc_init,
  input  logic [2:0]        cfg_setup,
  input  logic [2:0]        cfg_strobe,
  input  logic [2:0]        cfg_hold,
  input  logic              host_req,
  input  logic [1:0]        host_op,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              stat_ready,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb,
  output logic              ecc_init_pulse,
  output logic              ecc_byte_valid,
  output logic [DATA_W-1:0] ecc_byte
);
  logic    en_w;
  timing_t timing_w;
  logic    accept_w;
  logic    phase_done_w;

  nand_cfg_regs #(.WIDE_SETUP(WIDE_SETUP)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_enable   (cfg_enable),
    .cfg_chip_off (cfg_chip_off),
    .cfg_ecc_init (cfg_ecc_init),
    .cfg_setup    (cfg_setup),
    .cfg_strobe   (cfg_strobe),
    .cfg_hold     (cfg_hold),
    .en_q         (en_w),
    .ce_n_q       (nand_ce_n),
    .timing_q     (timing_w),
    .init_pulse_q (ecc_init_pulse)
  );

  nand_phase_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_w),
    .timing     (timing_w),
    .req        (host_req),
    .op         (host_op),
    .wdata      (host_wdata),
    .dq_in      (nand_dq_in),
    .ready      (host_ready),
    .ack        (host_ack),
    .rdata      (host_rdata),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .dq_out     (nand_dq_out),
    .dq_oe      (nand_dq_oe),
    .ecc_valid  (ecc_byte_valid),
    .ecc_byte   (ecc_byte),
    .accept     (accept_w),
    .phase_done (phase_done_w)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nand_rb),
    .rb_sync  (stat_ready)
  );

  // R13: an acknowledge is only ever raised by a phase that finished
  assert_ack_after_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(phase_done_w));

  // R8: chip enable does not move when a cycle starts
  assert_ce_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !cfg_we) |=> $stable(nand_ce_n));

endmodule

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
  localparam bit WIDE = 1'b0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, cfg_enable = 0, cfg_chip_off = 1, cfg_ecc_init = 0;
  logic [2:0] cfg_setup = 0, cfg_strobe = 0, cfg_hold = 0;
  logic       host_req = 0;
  logic [1:0] host_op = 0;
  logic [7:0] host_wdata = 0;
  logic       host_ready, host_ack, stat_ready;
  logic [7:0] host_rdata, nand_dq_out, ecc_byte;
  logic       nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_in = 0;
  logic       nand_rb = 0;
  logic       ecc_init_pulse, ecc_byte_valid;

  int checks = 0;
  int errors = 0;
  int cur_s = 0, cur_w = 0, cur_h = 0;
  logic cur_en = 0, cur_off = 1;

  always #4 clk = ~clk;

  nand_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_chip_off(cfg_chip_off), .cfg_ecc_init(cfg_ecc_init), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .host_req(host_req), .host_op(host_op),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_ack(host_ack),
    .host_rdata(host_rdata), .stat_ready(stat_ready), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .ecc_init_pulse(ecc_init_pulse),
    .ecc_byte_valid(ecc_byte_valid), .ecc_byte(ecc_byte)
  );

  function automatic int exp_setup(input int f);
    if (WIDE) return f + 1;
    return (f % 4) + 1;
  endfunction

  function automatic int exp_ticks(input int f);
    return f + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic en, input logic off, input logic init,
                           input int s, input int w, input int h);
    @(negedge clk);
    cfg_we = 1; cfg_enable = en; cfg_chip_off = off; cfg_ecc_init = init;
    cfg_setup = s[2:0]; cfg_strobe = w[2:0]; cfg_hold = h[2:0];
    @(negedge clk);
    cfg_we = 0; cfg_ecc_init = 0;
    cur_en = en; cur_off = off; cur_s = s; cur_w = w; cur_h = h;
  endtask

  // mode 0: plain, 1: config write on the accepting edge, 2: config write mid-cycle
  task automatic run_cycle(input logic [1:0] op, input logic [7:0] data, input int mode,
                           input int ns, input int nw, input int nh);
    int es, ew, eh, pre, str, post, ecc_n, ecc_v;
    bit seen, done, lines_bad, busy_bad, rdy_at_ack;
    logic [7:0] rbase, got;
    es = exp_setup(cur_s); ew = exp_ticks(cur_w); eh = exp_ticks(cur_h);
    pre = 0; str = 0; post = 0; ecc_n = 0; ecc_v = 0;
    seen = 0; done = 0; lines_bad = 0; busy_bad = 0; rdy_at_ack = 0;
    rbase = 8'($urandom_range(0, 255)); got = 0;
    @(negedge clk);
    check(host_ready == 1'b1, "R13 ready before request", int'(host_ready), 1);
    host_req = 1; host_op = op; host_wdata = data; nand_dq_in = 8'h00;
    if (mode == 1) begin
      cfg_we = 1; cfg_setup = ns[2:0]; cfg_strobe = nw[2:0]; cfg_hold = nh[2:0];
      cfg_enable = cur_en; cfg_chip_off = cur_off;
    end
    for (int k = 0; k < 100 && !done; k++) begin
      @(negedge clk);
      if (k == 0) begin
        host_req = 0;
        if (mode == 1) cfg_we = 0;
        if (mode == 2) begin
          cfg_we = 1; cfg_setup = ns[2:0]; cfg_strobe = nw[2:0]; cfg_hold = nh[2:0];
          cfg_enable = cur_en; cfg_chip_off = cur_off;
        end
      end
      if (k == 1 && mode == 2) cfg_we = 0;
      if (host_ack) begin
        done = 1; got = host_rdata; rdy_at_ack = host_ready;
      end else begin
        if (host_ready) busy_bad = 1;
        if (nand_cle != (op == 2'd0) || nand_ale != (op == 2'd1)) lines_bad = 1;
        if (nand_dq_oe != (op != 2'd3)) lines_bad = 1;
        if (op != 2'd3 && nand_dq_out != data) lines_bad = 1;
        if ((op == 2'd3 && !nand_we_n) || (op != 2'd3 && !nand_re_n)) lines_bad = 1;
        if ((op == 2'd3) ? !nand_re_n : !nand_we_n) begin
          str++; seen = 1;
          if (op == 2'd3) nand_dq_in = rbase + 8'(str);
        end else if (!seen) pre++;
        else begin
          post++; nand_dq_in = 8'hFF;
        end
        if (ecc_byte_valid) begin
          ecc_n++; ecc_v = int'(ecc_byte);
          if (post != 1) lines_bad = 1;
        end
      end
    end
    if (mode != 0) begin cur_s = ns; cur_w = nw; cur_h = nh; end
    check(done, "R13 acknowledge seen", int'(done), 1);
    check(rdy_at_ack, "R13 ready in ack cycle", int'(rdy_at_ack), 1);
    check(!busy_bad, "R13 ready low during cycle", int'(busy_bad), 0);
    check(pre == es, (es != (cur_s % 4) + 1 || mode != 0) ? "R14 setup" : "R5 R6 setup", pre, es);
    check(str == ew, mode != 0 ? "R14 strobe" : "R5 strobe", str, ew);
    check(post == eh, mode != 0 ? "R14 hold" : "R5 hold", post, eh);
    case (op)
      2'd0: check(!lines_bad, "R2 command lines", int'(lines_bad), 0);
      2'd1: check(!lines_bad, "R3 address lines", int'(lines_bad), 0);
      2'd2: check(!lines_bad, "R4 write lines", int'(lines_bad), 0);
      default: check(!lines_bad, "R7 read lines", int'(lines_bad), 0);
    endcase
    if (op == 2'd3) begin
      check(got == rbase + 8'(ew), "R7 read data", int'(got), int'(rbase + 8'(ew)));
      check(ecc_n == 1 && ecc_v == int'(rbase + 8'(ew)), "R12 read ecc byte", ecc_v,
            int'(rbase + 8'(ew)));
    end else if (op == 2'd2) begin
      check(ecc_n == 1 && ecc_v == int'(data), "R12 write ecc byte", ecc_v, int'(data));
    end else begin
      check(ecc_n == 0, "R12 no ecc on cmd/addr", ecc_n, 0);
    end
    check(nand_ce_n == cur_off, "R8 chip enable held", int'(nand_ce_n), int'(cur_off));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    bit bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(nand_ce_n == 1, "R1 ce_n", int'(nand_ce_n), 1);
    check(nand_we_n == 1 && nand_re_n == 1, "R1 strobes", int'({nand_we_n, nand_re_n}), 3);
    check(!nand_cle && !nand_ale && !nand_dq_oe, "R1 lines", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
    check(!host_ready && !host_ack, "R1 handshake", int'({host_ready, host_ack}), 0);
    check(!ecc_init_pulse && !ecc_byte_valid, "R1 ecc", int'({ecc_init_pulse, ecc_byte_valid}), 0);

    // R10 requests ignored while disabled
    host_req = 1; host_op = 2'd2; bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!nand_we_n || !nand_re_n || host_ack || host_ready) bad = 1;
    end
    host_req = 0;
    check(!bad, "R10 disabled ignores request", int'(bad), 0);

    // R8 and R11
    cfg_write(1, 0, 0, 0, 0, 0);
    check(ecc_init_pulse == 0, "R11 no pulse without init", int'(ecc_init_pulse), 0);
    check(nand_ce_n == 0, "R8 ce_n asserted", int'(nand_ce_n), 0);
    cfg_write(1, 0, 1, 0, 0, 0);
    pulses = int'(ecc_init_pulse);
    for (int k = 0; k < 3; k++) begin @(negedge clk); pulses += int'(ecc_init_pulse); end
    check(pulses == 1, "R11 single init pulse", pulses, 1);

    // Directed corners
    run_cycle(2'd0, 8'h70, 0, 0, 0, 0);
    run_cycle(2'd0, 8'h90, 0, 0, 0, 0);
    cfg_write(1, 0, 0, 3, 7, 7);
    run_cycle(2'd1, 8'h3C, 0, 0, 0, 0);
    cfg_write(1, 0, 0, 6, 2, 1);
    run_cycle(2'd2, 8'hA5, 0, 0, 0, 0);
    run_cycle(2'd3, 8'h00, 0, 0, 0, 0);

    // R14 config on the accepting edge, then mid-cycle
    run_cycle(2'd2, 8'h11, 1, 1, 4, 2);
    run_cycle(2'd3, 8'h00, 2, 2, 0, 5);
    run_cycle(2'd1, 8'h22, 0, 0, 0, 0);

    // R8 chip enable released, held across a cycle
    cfg_write(1, 1, 0, 1, 1, 1);
    check(nand_ce_n == 1, "R8 ce_n released", int'(nand_ce_n), 1);
    run_cycle(2'd0, 8'hFF, 0, 0, 0, 0);

    // R9 synchroniser latency
    @(negedge clk); nand_rb = 1;
    @(negedge clk); check(stat_ready == 0, "R9 not after one edge", int'(stat_ready), 0);
    @(negedge clk); check(stat_ready == 1, "R9 ready after two edges", int'(stat_ready), 1);
    nand_rb = 0;
    @(negedge clk); check(stat_ready == 1, "R9 busy not after one edge", int'(stat_ready), 1);
    @(negedge clk); check(stat_ready == 0, "R9 busy after two edges", int'(stat_ready), 0);

    // R10 disable in the middle of a strobe
    cfg_write(1, 0, 0, 0, 7, 0);
    @(negedge clk); host_req = 1; host_op = 2'd2; host_wdata = 8'h5A;
    @(negedge clk); host_req = 0;
    while (nand_we_n) @(negedge clk);
    cfg_write(0, 0, 0, 0, 7, 0);
    @(negedge clk);
    check(nand_we_n == 1 && nand_re_n == 1, "R10 strobe dropped", int'(nand_we_n), 1);
    check(host_ready == 0, "R10 ready low", int'(host_ready), 0);
    bad = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (host_ack || !nand_we_n) bad = 1; end
    check(!bad, "R10 no ack after abort", int'(bad), 0);
    cfg_write(1, 0, 0, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      if ((n % 5) == 0)
        cfg_write(1, 0, 0, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      run_cycle(2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)), 0, 0, 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule